// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus from the oscillator clock. The first is an address latch pulse that an external latch uses to hold the low address byte. The second is an active-low program read strobe that gates code fetches from external memory. A free-running phase counter divides the oscillator into machine cycles. The address latch pulse fires twice in each machine cycle, so it normally runs at a fixed one sixth of the oscillator rate. Downstream logic can also use it as a slow timing reference.

The control inputs are sampled on the last phase of each machine cycle and take effect for the whole of the next cycle. They are:
- an indicator that the cycle is an external data access;
- an indicator that a code-read instruction is running;
- an external-execution mode input;
- a latch-disable control bit.

In an external data cycle, the second latch pulse and both program read strobes are dropped. When the latch-disable bit is set, the latch pulse is parked high with its strong driver off. Pulses still occur during data-access and code-read instructions. External execution mode overrides the disable bit.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: A machine cycle is CYC_LEN oscillator periods, and phase 0 follows reset. All four control inputs are captured on the last phase of a cycle and hold for the whole next cycle, so a change mid-cycle alters nothing until the following cycle.
- R2: With the latch enabled and no data access, `ale` is 1 in phases 0..PULSE_W-1 and HALF..HALF+PULSE_W-1 (HALF = CYC_LEN/2) and 0 otherwise. With the defaults this is phases 0,1,6,7 of 12, one sixth of the clock rate.
- R3: In a cycle marked as an external data access, the first latch pulse (phases 0..PULSE_W-1) is kept and the second one is suppressed.
- R4: With `latch_off`=1 and none of `ext_exec`, `xdata_cyc`, `code_rd_op` set, `ale` stays 1 for the whole cycle and `ale_drive` is 0 (weak pull-up only).
- R5: With `latch_off`=1, a code-read instruction or an external data access re-enables the latch pulse for that cycle, with `ale_drive`=1 and the pattern of R2/R3.
- R6: `latch_off` has no effect while `ext_exec`=1: the latch pulse runs as in R2/R3 with `ale_drive`=1.
- R7: With `ext_exec`=1 and no data access, `prog_rd_n` is 0 in phases HALF-RD_W..HALF-1 and CYC_LEN-RD_W..CYC_LEN-1 (phases 3-5 and 9-11 by default) and 1 elsewhere. These two strobes never overlap a driven latch pulse.
- R8: In an external data access cycle, both program read strobes are skipped and `prog_rd_n` stays 1.
- R9: With `ext_exec`=0 (internal fetch), `prog_rd_n` stays 1.
- R10: While reset is asserted, `ale`=1, `ale_drive`=1 and `prog_rd_n`=1. The captured disable bit clears to 0, so the first cycle after reset shows an enabled latch pulse even if `latch_off` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xdata_cyc | input | 1 | Next machine cycle is an external data memory access |
| code_rd_op | input | 1 | A code-read instruction is executing |
| ext_exec | input | 1 | Code executes from external program memory |
| latch_off | input | 1 | Latch-disable control bit |
| ale | output | 1 | Address latch pulse, active high |
| ale_drive | output | 1 | 1 when `ale` is strongly driven; 0 when only weakly held high |
| prog_rd_n | output | 1 | Program read strobe, active low |

## Verification
The bench builds the block with the default parameters: a 12-period machine cycle, 2-period latch pulses and 3-period read strobes. With these values every phase position of both strobes is visible, including the suppressed second latch slot and the two skipped read strobes. Each control combination is applied for a full machine cycle, and the resulting 12-phase pattern is compared as a whole. Directed cases cover the reset state, the disable bit being cleared at reset, and a control change made in the middle of a cycle.

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen #(
  parameter int CYC_LEN = 12,
  parameter int PULSE_W = 2,
  parameter int RD_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xdata_cyc,
  input  logic code_rd_op,
  input  logic ext_exec,
  input  logic latch_off,
  output logic ale,
  output logic ale_drive,
  output logic prog_rd_n
);
  localparam int HALF = CYC_LEN / 2;
  localparam int PH_W = $clog2(CYC_LEN);
  typedef logic [PH_W-1:0] ph_t;
  localparam ph_t P_LAST = ph_t'(CYC_LEN - 1);
  localparam ph_t P_HALF = ph_t'(HALF);
  localparam ph_t P_PW   = ph_t'(PULSE_W);
  localparam ph_t P_HEND = ph_t'(HALF + PULSE_W);
  localparam ph_t P_RD0  = ph_t'(HALF - RD_W);
  localparam ph_t P_RD1  = ph_t'(CYC_LEN - RD_W);

  ph_t  phase;
  logic xd_q, cr_q, ex_q, off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      xd_q  <= 1'b0;
      cr_q  <= 1'b0;
      ex_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      phase <= (phase == P_LAST) ? '0 : phase + 1'b1;
      if (phase == P_LAST) begin
        xd_q  <= xdata_cyc;
        cr_q  <= code_rd_op;
        ex_q  <= ext_exec;
        off_q <= latch_off;
      end
    end
  end

  logic slot_a, slot_b, rd_slot, latch_en;
  assign slot_a   = phase < P_PW;
  assign slot_b   = (phase >= P_HALF) && (phase < P_HEND);
  assign rd_slot  = ((phase >= P_RD0) && (phase < P_HALF)) || (phase >= P_RD1);
  assign latch_en = !off_q || ex_q || xd_q || cr_q;

  assign ale       = latch_en ? (slot_a || (slot_b && !xd_q)) : 1'b1;
  assign ale_drive = latch_en;
  assign prog_rd_n = !(ex_q && !xd_q && rd_slot);

  a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> $stable({xd_q, cr_q, ex_q, off_q}));
  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ((PULSE_W > 1) && $rose(ale)) |=> ale);
  a_r3_second_half_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (xd_q && phase >= P_HALF) |-> !(ale && ale_drive));
  a_r4_weak_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_drive |-> ale);
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && ale_drive) |-> prog_rd_n);
  a_r9_internal_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_q |-> prog_rd_n);
endmodule

// File: tb/ext_bus_strobe_gen_tb.sv
`timescale 1ns/1ps
module ext_bus_strobe_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xdata_cyc = 0, code_rd_op = 0, ext_exec = 0, latch_off = 0;
  logic ale, ale_drive, prog_rd_n;
  int checks = 0, fails = 0;
  bit done = 0;
  int ph;

  always #2 clk = ~clk;

  ext_bus_strobe_gen u_dut (.clk(clk), .rst_n(rst_n), .xdata_cyc(xdata_cyc),
    .code_rd_op(code_rd_op), .ext_exec(ext_exec), .latch_off(latch_off),
    .ale(ale), .ale_drive(ale_drive), .prog_rd_n(prog_rd_n));

  always_ff @(posedge clk)
    if (!rst_n) ph <= 0; else ph <= (ph == 11) ? 0 : ph + 1;

  // {latch_off, ext_exec, xdata_cyc, code_rd_op, ale mask, drive, prog_rd_n mask}
  localparam logic [28:0] VEC [10] = '{
    {4'b0000, 12'h0C3, 1'b1, 12'hFFF},  // R2 R9
    {4'b0010, 12'h003, 1'b1, 12'hFFF},  // R3
    {4'b0100, 12'h0C3, 1'b1, 12'h1C7},  // R7
    {4'b0110, 12'h003, 1'b1, 12'hFFF},  // R8
    {4'b1000, 12'hFFF, 1'b0, 12'hFFF},  // R4
    {4'b1001, 12'h0C3, 1'b1, 12'hFFF},  // R5
    {4'b1010, 12'h003, 1'b1, 12'hFFF},  // R5
    {4'b1100, 12'h0C3, 1'b1, 12'h1C7},  // R6
    {4'b1110, 12'h003, 1'b1, 12'hFFF},  // R6
    {4'b0001, 12'h0C3, 1'b1, 12'hFFF}   // R2
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2"; 1: return "R3"; 2: return "R7"; 3: return "R8";
      4: return "R4"; 5: return "R5"; 6: return "R5"; 7: return "R6";
      8: return "R6"; default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic capture(bit wait_start, output logic [11:0] a, output logic [11:0] d,
                         output logic [11:0] p);
    if (wait_start) begin
      @(negedge clk);
      while (ph != 0) @(negedge clk);
    end
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      a[i] = ale; d[i] = ale_drive; p[i] = prog_rd_n;
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] a, d, p;
    latch_off = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", {9'd0, ale, ale_drive, prog_rd_n}, 12'h007, "reset outputs");
    rst_n = 1'b1;
    capture(0, a, d, p);  // first cycle after reset, latch_off held 1
    check("R10", a, 12'h0C3, "ale after reset");
    check("R10", d, 12'hFFF, "drive after reset");
    check("R10", p, 12'hFFF, "prog_rd_n after reset");

    for (int v = 0; v < 10; v++) begin
      {latch_off, ext_exec, xdata_cyc, code_rd_op} = VEC[v][28:25];
      capture(1, a, d, p);
      check(tag_of(v), a, VEC[v][24:13], $sformatf("ale vec %0d", v));
      check(tag_of(v), d, {12{VEC[v][12]}}, $sformatf("drive vec %0d", v));
      check(tag_of(v), p, VEC[v][11:0], $sformatf("prog_rd_n vec %0d", v));
    end

    // R1: change in mid-cycle applies only from the next cycle
    {latch_off, ext_exec, xdata_cyc, code_rd_op} = 4'b0100;
    @(negedge clk);
    while (ph != 0) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 4) {latch_off, ext_exec, xdata_cyc, code_rd_op} = 4'b1000;
      a[i] = ale; d[i] = ale_drive; p[i] = prog_rd_n;
    end
    check("R1", a, 12'h0C3, "ale in change cycle");
    check("R1", p, 12'h1C7, "prog_rd_n in change cycle");
    capture(1, a, d, p);
    check("R1", a, 12'hFFF, "ale next cycle");
    check("R1", d, 12'h000, "drive next cycle");
    check("R1", p, 12'hFFF, "prog_rd_n next cycle");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule